// File: doc/BRIEF.md
# Guarded Page-Write Controller for a 128-Byte Data Array

This block governs writes to a small nonvolatile data array of 128 bytes that sits at the very top of a 16-bit data address space (FF80h to FFFFh). A host talks to it over a plain bus: an address, a byte of write data, a one-cycle write strobe and a combinational read-data return. The array is split into two 64-byte pages. A write to the window does not change the array at once. It opens a page-load phase that collects bytes into a 64-byte staging buffer. Once the host stops writing for a set number of cycles, the controller runs a timed programming cycle with a busy flag, then commits the staged bytes.

A command tracker watches writes made while the controller is idle. Fixed three-byte and six-byte command sequences switch write protection on, switch it off, or wipe the whole array. While protection is on, a data load is accepted only straight after the three-byte lock sequence, and that sequence opens one page-load phase. The inter-byte timeout and the programming time are parameters counted in clock cycles. The array itself is a register model.

Top module: `nvpage_ctl`

## Requirements
- R1: Only addresses whose bits 15..7 are all ones (FF80h..FFFFh) reach the block. Writes outside that window have no effect and start no load, and reads outside it return 00h.
- R2: With protection off, a single write to the window stores that byte in the array once its load phase and programming cycle have finished.
- R3: Address bit 6 selects the page. The first byte of a load fixes the page. Later bytes of the other page are ignored, and bytes of the same page may arrive in any order.
- R4: Each accepted byte restarts the inter-byte timeout. Programming begins LOAD_TMO cycles after the last accepted byte, and array bytes that were not loaded keep their old values.
- R5: The busy output is high for exactly PROG_CYC cycles per programming cycle. Writes made while busy are dropped, and reads during a load or while busy return the old array contents.
- R6: The lock sequence (AAh to offset 55h, i.e. FFD5h; 55h to offset 2Ah, i.e. FFAAh; A0h to FFD5h) sets protection, and the load that follows it is accepted.
- R7: While protection is on, a data write that is not directly preceded by the lock sequence is ignored.
- R8: The six-write unlock sequence (AAh@FFD5h, 55h@FFAAh, 80h@FFD5h, AAh@FFD5h, 55h@FFAAh, 20h@FFD5h) clears protection.
- R9: The six-write wipe sequence (the same as R8 but ending with 10h@FFD5h) starts a programming cycle that sets all 128 bytes to FFh.
- R10: A write that matches a step of a command sequence is used up as a command and is not stored. A write that breaks a sequence returns the tracker to its start and is handled as an ordinary data write.
- R11: After reset, busy and protection are low, and the page buffer and the command tracker are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Data-space byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | One-cycle write strobe |
| rd_data | output | 8 | Array byte at bus_addr, or 00h outside the window |
| busy | output | 1 | Programming cycle in progress |
| prot_on | output | 1 | Write protection active |

## Verification
The hardest case to reach is a sequence that breaks partway through while protection is on. Two correct command steps are followed by a stray write, and then a proper unlock and load must still succeed. The bench builds this case from its write task and also covers the same break with protection off, where the breaking byte must be stored. A behavioural model advances in step with the design on every clock, so timeout restarts, dropped writes while busy and wipe timing are all compared cycle by cycle.

// File: rtl/nvpage_pkg.sv
package nvpage_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_LOAD = 2'd1,
        MD_PROG = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        SQ_S0 = 3'd0,
        SQ_S1 = 3'd1,
        SQ_S2 = 3'd2,
        SQ_S3 = 3'd3,
        SQ_S4 = 3'd4,
        SQ_S5 = 3'd5
    } step_e;

    localparam logic [6:0] OFF_HI  = 7'h55;
    localparam logic [6:0] OFF_LO  = 7'h2A;
    localparam logic [7:0] K_AA    = 8'hAA;
    localparam logic [7:0] K_55    = 8'h55;
    localparam logic [7:0] K_LOCK  = 8'hA0;
    localparam logic [7:0] K_EXT   = 8'h80;
    localparam logic [7:0] K_FREE  = 8'h20;
    localparam logic [7:0] K_WIPE  = 8'h10;
endpackage

// File: rtl/nvpage_seq.sv
module nvpage_seq
    import nvpage_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [IDX_W-1:0] off,
    input  logic [BYTE_W-1:0] data,
    output logic             take,
    output logic             ev_lock,
    output logic             ev_free,
    output logic             ev_wipe
);
    step_e step_d, step_q;
    step_e nxt;
    logic  at_hi, at_lo;

    always_comb begin
        at_hi   = (off == IDX_W'(OFF_HI));
        at_lo   = (off == IDX_W'(OFF_LO));
        nxt     = SQ_S0;
        take    = 1'b0;
        ev_lock = 1'b0;
        ev_free = 1'b0;
        ev_wipe = 1'b0;
        case (step_q)
            SQ_S0: if (at_hi && data == K_AA) begin take = 1'b1; nxt = SQ_S1; end
            SQ_S1: if (at_lo && data == K_55) begin take = 1'b1; nxt = SQ_S2; end
            SQ_S2: begin
                if (at_hi && data == K_LOCK) begin
                    take = 1'b1; ev_lock = 1'b1;
                end else if (at_hi && data == K_EXT) begin
                    take = 1'b1; nxt = SQ_S3;
                end
            end
            SQ_S3: if (at_hi && data == K_AA) begin take = 1'b1; nxt = SQ_S4; end
            SQ_S4: if (at_lo && data == K_55) begin take = 1'b1; nxt = SQ_S5; end
            SQ_S5: begin
                if (at_hi && data == K_FREE) begin
                    take = 1'b1; ev_free = 1'b1;
                end else if (at_hi && data == K_WIPE) begin
                    take = 1'b1; ev_wipe = 1'b1;
                end
            end
            default: nxt = SQ_S0;
        endcase
        if (!stb) begin
            take = 1'b0; ev_lock = 1'b0; ev_free = 1'b0; ev_wipe = 1'b0;
        end
        step_d = stb ? nxt : step_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= SQ_S0;
        else        step_q <= step_d;
    end
endmodule

// File: rtl/nvpage_cells.sv
module nvpage_cells
    import nvpage_pkg::*;
#(
    parameter int PAGE_BYTES = 64
) (
    input  logic                           clk,
    input  logic                           commit,
    input  logic                           wipe,
    input  logic                           page,
    input  logic [PAGE_BYTES-1:0]          vmask,
    input  logic [PAGE_BYTES*BYTE_W-1:0]   stage,
    input  logic [$clog2(PAGE_BYTES):0]    rd_idx,
    output logic [BYTE_W-1:0]              rd_byte
);
    localparam int TOTAL = 2 * PAGE_BYTES;

    logic [BYTE_W-1:0] mem_q [TOTAL];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < TOTAL; i++) begin
                if (wipe)
                    mem_q[i] <= {BYTE_W{1'b1}};
                else if ((i / PAGE_BYTES) == int'(page) && vmask[i % PAGE_BYTES])
                    mem_q[i] <= stage[(i % PAGE_BYTES)*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rd_byte = mem_q[rd_idx];
endmodule

// File: rtl/nvpage_ctl.sv
module nvpage_ctl
    import nvpage_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 64,
    parameter int LOAD_TMO   = 30000,
    parameter int PROG_CYC   = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              prot_on
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int IDX_W = OFF_W + 1;
    localparam int TMO_W = $clog2(LOAD_TMO + 1);
    localparam int PRG_W = $clog2(PROG_CYC + 1);

    typedef struct packed {
        mode_e                        mode;
        logic [TMO_W-1:0]             tmo;
        logic [PRG_W-1:0]             cnt;
        logic                         page;
        logic                         prot;
        logic                         unlk;
        logic                         erase;
        logic [PAGE_BYTES-1:0]        vmask;
        logic [PAGE_BYTES*BYTE_W-1:0] stage;
    } st_t;

    st_t st_d, st_q;

    logic             hit, wr_hit, seq_stb, commit;
    logic [IDX_W-1:0] off;
    logic [OFF_W-1:0] slot;
    logic             take, ev_lock, ev_free, ev_wipe;
    logic [7:0]       cell_rd;

    assign hit     = &bus_addr[ADDR_W-1:IDX_W];
    assign off     = bus_addr[IDX_W-1:0];
    assign slot    = off[OFF_W-1:0];
    assign wr_hit  = bus_wr && hit;
    assign seq_stb = wr_hit && (st_q.mode == MD_IDLE);

    nvpage_seq #(.IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (seq_stb),
        .off     (off),
        .data    (bus_wdata),
        .take    (take),
        .ev_lock (ev_lock),
        .ev_free (ev_free),
        .ev_wipe (ev_wipe)
    );

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        case (st_q.mode)
            MD_IDLE: begin
                if (seq_stb) begin
                    if (take) begin
                        if (ev_lock) begin
                            st_d.prot = 1'b1;
                            st_d.unlk = 1'b1;
                        end
                        if (ev_free) st_d.prot = 1'b0;
                        if (ev_wipe) begin
                            st_d.mode  = MD_PROG;
                            st_d.cnt   = '0;
                            st_d.erase = 1'b1;
                        end
                    end else if (!st_q.prot || st_q.unlk) begin
                        st_d.mode        = MD_LOAD;
                        st_d.page        = off[IDX_W-1];
                        st_d.tmo         = '0;
                        st_d.vmask       = '0;
                        st_d.vmask[slot] = 1'b1;
                        st_d.stage[slot*BYTE_W +: BYTE_W] = bus_wdata;
                    end
                end
            end
            MD_LOAD: begin
                if (wr_hit && off[IDX_W-1] == st_q.page) begin
                    st_d.vmask[slot] = 1'b1;
                    st_d.stage[slot*BYTE_W +: BYTE_W] = bus_wdata;
                    st_d.tmo = '0;
                end else if (st_q.tmo == TMO_W'(LOAD_TMO - 1)) begin
                    st_d.mode = MD_PROG;
                    st_d.cnt  = '0;
                    st_d.unlk = 1'b0;
                end else begin
                    st_d.tmo = st_q.tmo + 1'b1;
                end
            end
            MD_PROG: begin
                if (st_q.cnt == PRG_W'(PROG_CYC - 1)) begin
                    commit      = 1'b1;
                    st_d.mode   = MD_IDLE;
                    st_d.vmask  = '0;
                    st_d.erase  = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.mode = MD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    nvpage_cells #(.PAGE_BYTES(PAGE_BYTES)) u_cells (
        .clk     (clk),
        .commit  (commit),
        .wipe    (st_q.erase),
        .page    (st_q.page),
        .vmask   (st_q.vmask),
        .stage   (st_q.stage),
        .rd_idx  (off),
        .rd_byte (cell_rd)
    );

    assign rd_data = hit ? cell_rd : 8'h00;
    assign busy    = (st_q.mode == MD_PROG);
    assign prot_on = st_q.prot;
endmodule

// File: rtl/nvpage_chk.sv
module nvpage_chk #(
    parameter int ADDR_W   = 16,
    parameter int PROG_CYC = 50000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic [7:0]        rd_data,
    input logic              busy,
    input logic              prot_on
);
    localparam int CW = $clog2(PROG_CYC + 1) + 1;
    localparam logic [ADDR_W-1:0] CMD_ADDR = {{(ADDR_W-7){1'b1}}, 7'h55};

    logic [CW-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    p_busy_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < CW'(PROG_CYC)));

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bcnt) == CW'(PROG_CYC - 1)));

    p_hold_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(bus_addr)) |-> $stable(rd_data));

    p_lock_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(bus_wr && bus_addr == CMD_ADDR && bus_wdata == 8'hA0));

    p_free_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(bus_wr && bus_addr == CMD_ADDR && bus_wdata == 8'h20));
endmodule

bind nvpage_ctl nvpage_chk #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .rd_data   (rd_data),
    .busy      (busy),
    .prot_on   (prot_on)
);

// File: tb/nvpage_ctl_tb.sv
`timescale 1ns/1ps
module nvpage_ctl_tb;
    localparam int TMO  = 24;
    localparam int PRG  = 40;
    localparam int WAIT = TMO + PRG + 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  rd_data;
    logic        busy, prot_on;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    nvpage_ctl #(.ADDR_W(16), .PAGE_BYTES(64), .LOAD_TMO(TMO), .PROG_CYC(PRG)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .rd_data(rd_data), .busy(busy), .prot_on(prot_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int        m_mode, m_tmo, m_cnt, m_page, m_seq;
    bit        m_prot, m_unlk, m_erase;
    byte       m_buf [64];
    bit        m_val [64];
    byte       m_mem [128];
    bit        m_known [128];

    always @(negedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_tmo = 0; m_cnt = 0; m_page = 0; m_seq = 0;
            m_prot = 0; m_unlk = 0; m_erase = 0;
            foreach (m_val[i]) m_val[i] = 0;
        end else if (!done) begin
            bit hitb, w, tk;
            int o;
            hitb = (bus_addr[15:7] == 9'h1FF);
            o    = int'(bus_addr[6:0]);
            w    = bus_wr && hitb;
            chk("R5 model busy", int'(busy), int'(m_mode == 2));
            chk("R6 model prot", int'(prot_on), int'(m_prot));
            if (!hitb) chk("R1 model read outside", int'(rd_data), 0);
            else if (m_known[o]) chk("R2 model read", int'(rd_data), int'(m_mem[o]) & 255);
            case (m_mode)
                0: if (w) begin
                    tk = 1;
                    if (m_seq == 0 && o == 'h55 && bus_wdata == 8'hAA) m_seq = 1;
                    else if (m_seq == 1 && o == 'h2A && bus_wdata == 8'h55) m_seq = 2;
                    else if (m_seq == 2 && o == 'h55 && bus_wdata == 8'hA0) begin
                        m_seq = 0; m_prot = 1; m_unlk = 1;
                    end
                    else if (m_seq == 2 && o == 'h55 && bus_wdata == 8'h80) m_seq = 3;
                    else if (m_seq == 3 && o == 'h55 && bus_wdata == 8'hAA) m_seq = 4;
                    else if (m_seq == 4 && o == 'h2A && bus_wdata == 8'h55) m_seq = 5;
                    else if (m_seq == 5 && o == 'h55 && bus_wdata == 8'h20) begin
                        m_seq = 0; m_prot = 0;
                    end
                    else if (m_seq == 5 && o == 'h55 && bus_wdata == 8'h10) begin
                        m_seq = 0; m_mode = 2; m_cnt = 0; m_erase = 1;
                    end
                    else tk = 0;
                    if (!tk) begin
                        m_seq = 0;
                        if (!m_prot || m_unlk) begin
                            m_mode = 1; m_page = o / 64; m_tmo = 0;
                            foreach (m_val[i]) m_val[i] = 0;
                            m_val[o % 64] = 1; m_buf[o % 64] = byte'(bus_wdata);
                        end
                    end
                end
                1: begin
                    if (w && (o / 64) == m_page) begin
                        m_val[o % 64] = 1; m_buf[o % 64] = byte'(bus_wdata); m_tmo = 0;
                    end else if (m_tmo == TMO - 1) begin
                        m_mode = 2; m_cnt = 0; m_unlk = 0;
                    end else m_tmo++;
                end
                default: begin
                    if (m_cnt == PRG - 1) begin
                        for (int i = 0; i < 128; i++) begin
                            if (m_erase) begin m_mem[i] = byte'(8'hFF); m_known[i] = 1; end
                            else if (i / 64 == m_page && m_val[i % 64]) begin
                                m_mem[i] = m_buf[i % 64]; m_known[i] = 1;
                            end
                        end
                        m_mode = 0; m_erase = 0;
                        foreach (m_val[i]) m_val[i] = 0;
                    end else m_cnt++;
                end
            endcase
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        chk(tag, int'(rd_data), int'(e));
    endtask

    task automatic seq6(input logic [7:0] last);
        wr(16'hFFD5, 8'hAA); wr(16'hFFAA, 8'h55); wr(16'hFFD5, 8'h80);
        wr(16'hFFD5, 8'hAA); wr(16'hFFAA, 8'h55); wr(16'hFFD5, last);
    endtask

    task automatic lock3();
        wr(16'hFFD5, 8'hAA); wr(16'hFFAA, 8'h55); wr(16'hFFD5, 8'hA0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                done = 1'b1;
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 prot after reset", int'(prot_on), 0);

        // R9 wipe
        seq6(8'h10);
        idle(PRG + 4);
        rd_chk(16'hFFD0, 8'hFF, "R9 wipe high byte");
        rd_chk(16'hFF80, 8'hFF, "R9 wipe low byte");

        // R2 byte write, R5 old data during load and busy
        wr(16'hFF83, 8'h5A);
        rd_chk(16'hFF83, 8'hFF, "R5 old data during load");
        chk("R5 no busy during load", int'(busy), 0);
        idle(TMO + 5);
        chk("R5 busy in programming", int'(busy), 1);
        rd_chk(16'hFF83, 8'hFF, "R5 old data while busy");
        idle(PRG);
        rd_chk(16'hFF83, 8'h5A, "R2 byte stored");

        // R3 page load any order, other page ignored; R4 unloaded kept
        wr(16'hFFF0, 8'h11); wr(16'hFFC1, 8'h22); wr(16'hFF85, 8'h77); wr(16'hFFFF, 8'h33);
        idle(WAIT);
        rd_chk(16'hFFF0, 8'h11, "R3 page byte a");
        rd_chk(16'hFFC1, 8'h22, "R3 page byte b");
        rd_chk(16'hFFFF, 8'h33, "R3 page byte c");
        rd_chk(16'hFF85, 8'hFF, "R3 other page ignored");
        rd_chk(16'hFFC2, 8'hFF, "R4 unloaded byte kept");

        // R1 outside window
        wr(16'h1234, 8'h99);
        idle(TMO + 4);
        chk("R1 no load from outside write", int'(busy), 0);
        rd_chk(16'h1234, 8'h00, "R1 read outside");

        // R4 timeout restart
        wr(16'hFF88, 8'h01);
        idle(TMO - 4);
        chk("R4 still loading", int'(busy), 0);
        wr(16'hFF89, 8'h02);
        idle(TMO - 4);
        chk("R4 timeout restarted", int'(busy), 0);
        idle(WAIT);
        rd_chk(16'hFF88, 8'h01, "R4 first byte");
        rd_chk(16'hFF89, 8'h02, "R4 second byte");

        // R5 write while busy dropped
        wr(16'hFF90, 8'h77);
        idle(TMO + 4);
        wr(16'hFF91, 8'h66);
        idle(WAIT);
        rd_chk(16'hFF91, 8'hFF, "R5 busy write dropped");
        rd_chk(16'hFF90, 8'h77, "R2 second byte write");

        // R6 lock then one load
        lock3();
        @(negedge clk);
        chk("R6 protection set", int'(prot_on), 1);
        wr(16'hFFA0, 8'h44);
        idle(WAIT);
        rd_chk(16'hFFA0, 8'h44, "R6 unlocked load");
        // R7 plain write ignored
        wr(16'hFFA1, 8'h55);
        idle(WAIT);
        rd_chk(16'hFFA1, 8'hFF, "R7 guarded write ignored");

        // R10 broken sequence while protected
        wr(16'hFFD5, 8'hAA); wr(16'hFFAA, 8'h55); wr(16'hFFB0, 8'h12);
        idle(WAIT);
        rd_chk(16'hFFB0, 8'hFF, "R10 break ignored when guarded");
        lock3();
        wr(16'hFFB1, 8'h99);
        idle(WAIT);
        rd_chk(16'hFFB1, 8'h99, "R10 unlock after break");

        // R8 unlock
        seq6(8'h20);
        @(negedge clk);
        chk("R8 protection cleared", int'(prot_on), 0);
        wr(16'hFFA2, 8'h66);
        idle(WAIT);
        rd_chk(16'hFFA2, 8'h66, "R8 write after unlock");

        // R10 broken sequence unprotected: breaking byte stored
        wr(16'hFFD5, 8'hAA); wr(16'hFFB2, 8'h3C);
        idle(WAIT);
        rd_chk(16'hFFB2, 8'h3C, "R10 breaking write stored");
        rd_chk(16'hFFD5, 8'hFF, "R10 command byte not stored");

        // R9 wipe over written data
        seq6(8'h10);
        idle(PRG + 4);
        rd_chk(16'hFFA0, 8'hFF, "R9 wipe after data");
        rd_chk(16'hFFF0, 8'hFF, "R9 wipe page one");

        idle(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule